// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block keeps a DDR2-style SDRAM refreshed on behalf of a memory controller. A free-running interval timer counts controller clock cycles. Each time it expires, one refresh is owed. Owed refreshes collect in a small saturating counter. While that counter is non-zero the block raises a request toward the controller's arbiter. When the counter is full it also raises an urgent flag, so the arbiter can let refresh win over normal traffic.

When the arbiter grants the request, the block runs a refresh sequence on the command bus:

- If any bank is open, it first issues an all-bank precharge with A10 high and waits out the row-precharge time.
- It then issues REFRESH.
- It fills the refresh-cycle time with NOPs before handing the bus back.

When the device reports a case temperature above 85 °C, the interval is halved. The interval, precharge and refresh-cycle times are parameters in controller clock cycles. The normal interval must be chosen so that it is at most 7.8125 µs of clock time. At that spacing, 8192 refreshes fit inside 64 ms.

Top module: `refresh_sched`

## Requirements
- R1: After reset the outputs are NOP (111), A10 low, request low, urgent low and busy low. Request stays low until INTERVAL_CYC cycles after reset have elapsed.
- R2: With the temperature flag low, one refresh becomes owed every INTERVAL_CYC cycles. Request is high whenever at least one refresh is owed.
- R3: With the temperature flag high, one refresh becomes owed every INTERVAL_CYC/2 cycles.
- R4: The count of owed refreshes saturates at DEBT_MAX (8). Urgent is high exactly when the count equals DEBT_MAX.
- R5: When the block is idle, request is high, grant is high and the bank-open input is high, the next cycle drives PRECHARGE (010) with A10 high.
- R6: REFRESH (001) follows a PRECHARGE exactly TRP_CYC cycles later, with NOP (111) and A10 low in between.
- R7: When the block is idle, request is high, grant is high and the bank-open input is low, the next cycle drives REFRESH directly, with no precharge.
- R8: After REFRESH the command is NOP for TRFC_CYC-1 cycles. Busy falls exactly TRFC_CYC cycles after REFRESH.
- R9: Busy is high from the first command of a sequence until the refresh-cycle time ends. Grant has no effect while busy is high or while request is low.
- R10: Each REFRESH reduces the owed count by one. An interval expiry in the same cycle cancels the reduction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| hot_i | input | 1 | Case temperature above 85 °C |
| bank_open_i | input | 1 | At least one bank is active |
| grant_i | input | 1 | Arbiter grants the command bus to refresh |
| cmd_o | output | 3 | Command {RAS#, CAS#, WE#}: 111 NOP, 010 PRECHARGE, 001 REFRESH |
| a10_o | output | 1 | Address bit 10 level (high on precharge-all) |
| req_o | output | 1 | At least one refresh is owed |
| urgent_o | output | 1 | Owed count has reached its maximum |
| busy_o | output | 1 | A refresh sequence holds the command bus |

## Verification
The first command of a sequence is due one cycle after the grant is sampled, and a REFRESH that follows a precharge is due TRP_CYC cycles after it. Busy drops TRFC_CYC cycles after REFRESH. A new owed refresh, and with it request or urgent, shows one cycle after the interval timer expires. The bench model advances on the same rising edge as the design, reading inputs that were changed just after the previous edge. All outputs are compared at the falling edge, so each expected value lands in the same cycle as the design's. Separate event counters measure the precharge-to-refresh gap and the refresh-to-idle span directly in cycles.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

    typedef enum logic [2:0] {
        CMD_REF = 3'b001,
        CMD_PRE = 3'b010,
        CMD_NOP = 3'b111
    } sdram_cmd_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PRE,
        SQ_RP,
        SQ_REF,
        SQ_RFC
    } seq_state_e;

    function automatic int unsigned cnt_bits(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer
    import refresh_pkg::*;
#(
    parameter int unsigned INTERVAL_CYC = 1560
) (
    input  logic clk,
    input  logic rst,
    input  logic hot_i,
    output logic tick_o
);
    localparam int unsigned TW = cnt_bits(INTERVAL_CYC);
    localparam logic [TW-1:0] LIM_NORM = TW'(INTERVAL_CYC - 1);
    localparam logic [TW-1:0] LIM_HOT  = TW'(INTERVAL_CYC / 2 - 1);

    logic [TW-1:0] timer_q;
    logic [TW-1:0] limit;

    always_comb begin
        limit  = hot_i ? LIM_HOT : LIM_NORM;
        tick_o = (timer_q >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst)         timer_q <= '0;
        else if (tick_o) timer_q <= '0;
        else             timer_q <= timer_q + 1'b1;
    end

    // R2 / R3: the timer never runs past the longer limit
    a_r2_timer_bound: assert property (@(posedge clk) disable iff (rst)
        timer_q <= LIM_NORM);

endmodule

// File: rtl/refresh_debt_ctr.sv
module refresh_debt_ctr
    import refresh_pkg::*;
#(
    parameter int unsigned DEBT_MAX = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic ref_i,
    output logic req_o,
    output logic urgent_o
);
    localparam int unsigned DW = cnt_bits(DEBT_MAX);
    localparam logic [DW-1:0] CAP = DW'(DEBT_MAX);

    logic [DW-1:0] debt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            debt_q <= '0;
        end else if (tick_i && !ref_i) begin
            if (debt_q != CAP) debt_q <= debt_q + 1'b1;
        end else if (ref_i && !tick_i) begin
            debt_q <= debt_q - 1'b1;
        end
    end

    always_comb begin
        req_o    = (debt_q != '0);
        urgent_o = (debt_q == CAP);
    end

    a_r4_debt_cap: assert property (@(posedge clk) disable iff (rst)
        debt_q <= CAP);

    a_r10_ref_needs_debt: assert property (@(posedge clk) disable iff (rst)
        ref_i |-> (debt_q != '0));

    a_r2_req_from_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(req_o) |-> $past(tick_i));

endmodule

// File: rtl/refresh_seq_fsm.sv
module refresh_seq_fsm
    import refresh_pkg::*;
#(
    parameter int unsigned TRP_CYC  = 3,
    parameter int unsigned TRFC_CYC = 26
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_i,
    input  logic       grant_i,
    input  logic       bank_open_i,
    output sdram_cmd_e cmd_o,
    output logic       a10_o,
    output logic       busy_o,
    output logic       ref_o
);
    localparam int unsigned CW = cnt_bits(max2(TRP_CYC, TRFC_CYC));
    localparam logic [CW-1:0] RP_LOAD  = CW'(TRP_CYC - 2);
    localparam logic [CW-1:0] RFC_LOAD = CW'(TRFC_CYC - 2);

    seq_state_e    state_q;
    logic [CW-1:0] wait_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            wait_q  <= '0;
        end else begin
            unique case (state_q)
                SQ_IDLE: if (req_i && grant_i)
                             state_q <= bank_open_i ? SQ_PRE : SQ_REF;
                SQ_PRE:  begin
                             state_q <= SQ_RP;
                             wait_q  <= RP_LOAD;
                         end
                SQ_RP:   if (wait_q == '0) state_q <= SQ_REF;
                         else              wait_q  <= wait_q - 1'b1;
                SQ_REF:  begin
                             state_q <= SQ_RFC;
                             wait_q  <= RFC_LOAD;
                         end
                SQ_RFC:  if (wait_q == '0) state_q <= SQ_IDLE;
                         else              wait_q  <= wait_q - 1'b1;
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd_o  = CMD_NOP;
        a10_o  = 1'b0;
        busy_o = (state_q != SQ_IDLE);
        ref_o  = (state_q == SQ_REF);
        if (state_q == SQ_PRE) begin
            cmd_o = CMD_PRE;
            a10_o = 1'b1;
        end else if (state_q == SQ_REF) begin
            cmd_o = CMD_REF;
        end
    end

    a_r5_pre_all_banks: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_PRE) |-> a10_o);

    a_r8_nop_after_ref: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_REF) |=> (cmd_o == CMD_NOP));

    a_r9_cmd_only_busy: assert property (@(posedge clk) disable iff (rst)
        (cmd_o != CMD_NOP) |-> busy_o);

    a_r6_ref_source: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_PRE) |=> (cmd_o == CMD_NOP) && busy_o);

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refresh_pkg::*;
#(
    parameter int unsigned INTERVAL_CYC = 1560,
    parameter int unsigned TRP_CYC      = 3,
    parameter int unsigned TRFC_CYC     = 26,
    parameter int unsigned DEBT_MAX     = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hot_i,
    input  logic       bank_open_i,
    input  logic       grant_i,
    output logic [2:0] cmd_o,
    output logic       a10_o,
    output logic       req_o,
    output logic       urgent_o,
    output logic       busy_o
);
    logic       tick;
    logic       ref_pulse;
    sdram_cmd_e cmd_e;

    refresh_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .hot_i  (hot_i),
        .tick_o (tick)
    );

    refresh_debt_ctr #(.DEBT_MAX(DEBT_MAX)) u_debt (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick),
        .ref_i    (ref_pulse),
        .req_o    (req_o),
        .urgent_o (urgent_o)
    );

    refresh_seq_fsm #(.TRP_CYC(TRP_CYC), .TRFC_CYC(TRFC_CYC)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req_o),
        .grant_i     (grant_i),
        .bank_open_i (bank_open_i),
        .cmd_o       (cmd_e),
        .a10_o       (a10_o),
        .busy_o      (busy_o),
        .ref_o       (ref_pulse)
    );

    assign cmd_o = cmd_e;

    // R9: a sequence starts only when refresh is owed
    a_r9_start_needs_req: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(req_o) && $past(grant_i));

endmodule

// File: tb/refresh_sched_bench.sv
module refresh_sched_bench;
    localparam int INTERVAL = 40;
    localparam int TRP      = 3;
    localparam int TRFC     = 8;
    localparam int DMAX     = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hot_i = 1'b0;
    logic       bank_open_i = 1'b0;
    logic       grant_i = 1'b0;
    logic [2:0] cmd_o;
    logic       a10_o, req_o, urgent_o, busy_o;

    refresh_sched #(
        .INTERVAL_CYC(INTERVAL), .TRP_CYC(TRP), .TRFC_CYC(TRFC), .DEBT_MAX(DMAX)
    ) u_refresh_sched (
        .clk(clk), .rst(rst), .hot_i(hot_i), .bank_open_i(bank_open_i),
        .grant_i(grant_i), .cmd_o(cmd_o), .a10_o(a10_o), .req_o(req_o),
        .urgent_o(urgent_o), .busy_o(busy_o)
    );

    always #10 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // behavioural reference: phase 0 idle, 1 precharge, 2 tRP gap, 3 refresh, 4 tRFC gap
    int m_tmr, m_owed, m_phase, m_left;
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_tmr = 0; m_owed = 0; m_phase = 0; m_left = 0;
        end else begin
            int lim;
            bit expire, did_ref;
            lim     = hot_i ? INTERVAL / 2 : INTERVAL;
            expire  = (m_tmr + 1 >= lim);
            did_ref = (m_phase == 3);
            case (m_phase)
                0: if (m_owed > 0 && grant_i) m_phase = bank_open_i ? 1 : 3;
                1: begin m_phase = 2; m_left = TRP - 1; end
                2: begin m_left--; if (m_left == 0) m_phase = 3; end
                3: begin m_phase = 4; m_left = TRFC - 1; end
                default: begin m_left--; if (m_left == 0) m_phase = 0; end
            endcase
            m_tmr  = expire ? 0 : m_tmr + 1;
            m_owed = m_owed + (expire ? 1 : 0) - (did_ref ? 1 : 0);
            if (m_owed > DMAX) m_owed = DMAX;
        end
    end

    int  pre_at = -1, ref_at = -1;
    bit  busy_d = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            int ecmd;
            ecmd = (m_phase == 1) ? 3'b010 : (m_phase == 3) ? 3'b001 : 3'b111;
            chk("R5 R6 R7 R8 cmd", cmd_o, ecmd);
            chk("R5 a10", a10_o, m_phase == 1);
            chk("R9 busy", busy_o, m_phase != 0);
            chk(hot_i ? "R3 R10 req" : "R1 R2 R10 req", req_o, m_owed > 0);
            chk("R4 urgent", urgent_o, m_owed == DMAX);
            if (cmd_o == 3'b010) pre_at = cyc;
            if (cmd_o == 3'b001) begin
                if (pre_at >= 0) chk("R6 pre-to-ref gap", cyc - pre_at, TRP);
                pre_at = -1;
                ref_at = cyc;
            end
            if (busy_d && !busy_o) chk("R8 ref-to-idle span", cyc - ref_at, TRFC);
            busy_d = busy_o;
        end
    end

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        chk("R1 cmd at reset", cmd_o, 3'b111);
        chk("R1 a10 at reset", a10_o, 0);
        chk("R1 req at reset", req_o, 0);
        chk("R1 urgent at reset", urgent_o, 0);
        chk("R1 busy at reset", busy_o, 0);
        @(posedge clk); #1 rst = 1'b0;
        run(INTERVAL * (DMAX + 2));            // R4: saturate with no grant
        bank_open_i = 1'b1; grant_i = 1'b1;    // R5 R6: precharge path
        run(300);
        bank_open_i = 1'b0;                    // R7: direct refresh
        run(300);
        grant_i = 1'b0; hot_i = 1'b1;          // R3: halved interval
        run(200);
        for (int k = 0; k < 60; k++) begin     // R9: grant while busy ignored
            grant_i = k[0]; bank_open_i = k[2];
            run(7);
        end
        hot_i = 1'b0; grant_i = 1'b1;
        run(200);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule